// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block manages up to 32 general-purpose pins behind a 32-bit register interface. Each pin can be an output or an input. An output pin drives a level held in a register. An input pin passes through a multi-flop synchroniser before any logic uses it.

Every pin also has a trigger detector. It can sense a high level, a low level, a rising edge, a falling edge, or (when the build includes it) either edge. Detected events collect in a per-pin status latch. Each latch is masked by a per-pin enable bit. All enabled latches are OR-ed onto one interrupt line.

Software reaches the block through a single request channel. A request carries valid, write, a byte address and write data. The block can always take a request, so `req_ready` stays high and there is never back-pressure. Read data comes back with `rsp_valid` exactly one cycle after the read is accepted. The response channel cannot be stalled, so the requester must take the data in that cycle. Writes produce no response.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers are decoded on byte address bits [5:2], and the low two address bits are ignored. The map is: 0x00 pin level, 0x04 direction, 0x08 enable, 0x0C raw status (read-only), 0x10 pending (read-only), 0x14 clear (write-only, reads 0), 0x18 edge select, 0x1C polarity, 0x20 version (read-only), 0x24 both-edge select. Any other address reads 0, and writes to it have no effect.
- R2: A direction bit of 1 makes the pin an input and 0 makes it an output. `pin_oe[n]` is the inverse of direction bit n, and pin n sits at bit n of every per-pin register.
- R3: Writing offset 0x00 sets `pin_out`. Reading offset 0x00 returns, for each pin, the synchronised input level if the pin is an input, or the driven level if it is an output.
- R4: A pin input reaches register reads after two clock edges. An enabled interrupt caused by an input change reaches `irq` on the third clock edge after the change.
- R5: When the edge-select bit is 0, the pin is level sensed: polarity 1 means active high and polarity 0 means active low. The status bit is set again on every cycle the level holds, so a clear has no lasting effect while the level persists.
- R6: When the edge-select bit is 1 and the both-edge bit is 0, polarity 1 senses rising edges and polarity 0 senses falling edges. The status bit stays set after the pin returns to its idle level.
- R7: When both the edge-select bit and the both-edge bit are 1, every transition sets the status bit and the polarity bit is ignored. In that build the version register reads 3. A build without both-edge support reads 2 and has a both-edge register that reads 0.
- R8: Writing a 1 to a bit of the clear register clears that status bit. A 0 leaves it unchanged. If a detector event arrives in the same cycle as the clear, the event wins. Status bits are cleared by nothing else.
- R9: The pending register is status AND enable, and `irq` is the OR of all pending bits. A pin whose enable bit is 0 never reaches `irq`.
- R10: The enable register changes only on a write to offset 0x08. Several pins raising events in the same cycle leave it unchanged.
- R11: `req_ready` is always 1. `rsp_valid` is high in exactly the cycles that follow an accepted read.
- R12: After reset, the registers hold these values: pin level 0, direction all ones (every pin an input), enable 0, edge select 0, polarity all ones, both-edge 0, status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | NPINS | Pin input levels (asynchronous) |
| pin_out | output | NPINS | Levels driven on output pins |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong synchroniser depth or a wrong previous-sample register changes when, or whether, a status bit appears. The bench's cycle model catches this on the first cycle `irq` or a status read diverges, which is three edges after the pin moves. A wrong trigger decode shows up as a status bit that is missing or spurious on the first transition of the pin under test. A corrupted enable or status latch shows at `irq` in the same cycle, and in the next pending or enable read.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;

  // word indices; software decodes these positions
  localparam logic [IDX_W-1:0] IDX_LEVEL = 4'd0;
  localparam logic [IDX_W-1:0] IDX_DIR   = 4'd1;
  localparam logic [IDX_W-1:0] IDX_EN    = 4'd2;
  localparam logic [IDX_W-1:0] IDX_RAW   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_PEND  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_ACK   = 4'd5;
  localparam logic [IDX_W-1:0] IDX_EDGE  = 4'd6;
  localparam logic [IDX_W-1:0] IDX_POL   = 4'd7;
  localparam logic [IDX_W-1:0] IDX_VER   = 4'd8;
  localparam logic [IDX_W-1:0] IDX_BOTH  = 4'd9;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[k] <= '0;
      else        stage[k] <= stage[k-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect #(
  parameter int NPINS    = 32,
  parameter bit HAS_BOTH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] edge_sel,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] both,
  output logic [NPINS-1:0] event_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    assign rise    = lvl[i] & ~prev_q[i];
    assign fall    = ~lvl[i] & prev_q[i];
    assign lvl_hit = pol[i] ? lvl[i] : ~lvl[i];
    if (HAS_BOTH) begin : g_both
      assign edge_hit = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
    end else begin : g_single
      assign edge_hit = pol[i] ? rise : fall;
    end
    assign event_o[i] = edge_sel[i] ? edge_hit : lvl_hit;
  end
endmodule

// File: rtl/gpio_irq_latch.sv
`timescale 1ns/1ps
module gpio_irq_latch #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] event_i,
  input  logic             clr_valid,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] status_o
);
  logic [NPINS-1:0] keep;

  assign keep = clr_valid ? ~clr_mask : '1;

  // event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= (status_o & keep) | event_i;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS         = 32,
  parameter int SYNC_STAGES   = 2,
  parameter bit HAS_BOTH_EDGE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [DATA_W-1:0] VERSION = HAS_BOTH_EDGE ? 32'd3 : 32'd2;

  logic [NPINS-1:0] out_q, dir_q, en_q, edge_q, pol_q, both_q;
  logic [NPINS-1:0] sync_lvl, trig_ev, status_q, pend;
  logic [NPINS-1:0] wfield;
  logic [IDX_W-1:0] idx;
  logic             wr, rd, clr_valid;
  logic [1:0]       unused_lsb;

  assign unused_lsb = req_addr[1:0];
  assign idx        = req_addr[ADDR_W-1:2];
  assign wr         = req_valid & req_write;
  assign rd         = req_valid & ~req_write;
  assign wfield     = req_wdata[NPINS-1:0];
  assign req_ready  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      en_q   <= '0;
      edge_q <= '0;
      pol_q  <= '1;
    end else if (wr) begin
      case (idx)
        IDX_LEVEL: out_q  <= wfield;
        IDX_DIR:   dir_q  <= wfield;
        IDX_EN:    en_q   <= wfield;
        IDX_EDGE:  edge_q <= wfield;
        IDX_POL:   pol_q  <= wfield;
        default: ;
      endcase
    end
  end

  if (HAS_BOTH_EDGE) begin : g_both_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    both_q <= '0;
      else if (wr && idx == IDX_BOTH) both_q <= wfield;
    end
  end else begin : g_no_both
    assign both_q = '0;
  end

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sync_lvl)
  );

  gpio_trig_detect #(.NPINS(NPINS), .HAS_BOTH(HAS_BOTH_EDGE)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .edge_sel(edge_q),
    .pol(pol_q), .both(both_q), .event_o(trig_ev)
  );

  assign clr_valid = wr && (idx == IDX_ACK);

  gpio_irq_latch #(.NPINS(NPINS)) u_latch (
    .clk(clk), .rst_n(rst_n), .event_i(trig_ev), .clr_valid(clr_valid),
    .clr_mask(wfield), .status_o(status_q)
  );

  assign pend    = status_q & en_q;
  assign irq     = |pend;
  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  logic [NPINS-1:0]  rfield;
  logic [DATA_W-1:0] rword;

  always_comb begin
    rfield = '0;
    rword  = '0;
    case (idx)
      IDX_LEVEL: rfield = (dir_q & sync_lvl) | (~dir_q & out_q);
      IDX_DIR:   rfield = dir_q;
      IDX_EN:    rfield = en_q;
      IDX_RAW:   rfield = status_q;
      IDX_PEND:  rfield = pend;
      IDX_EDGE:  rfield = edge_q;
      IDX_POL:   rfield = pol_q;
      IDX_BOTH:  rfield = both_q;
      IDX_VER:   rword  = VERSION;
      default: ;
    endcase
    rword[NPINS-1:0] = rword[NPINS-1:0] | rfield;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rword;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [5:0]       req_addr,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             irq,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] status_q
);
  // R11
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);

  // R11
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R10
  enable_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr[5:2] == 4'd2) |=> $stable(en_q));

  // R8
  status_no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr[5:2] == 4'd5)
      |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .irq(irq), .en_q(en_q), .status_q(status_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  localparam int N = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [5:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid, irq;
  logic [31:0]   rsp_rdata;
  logic [N-1:0]  pin_in = '0, pin_out, pin_oe;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0, started = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_out, m_dir, m_en, m_edge, m_pol, m_both, m_stat, m_rdata;
  logic [31:0] hist[$];
  logic [31:0] cur, prv, ev, clr;
  logic        m_rsp_v, m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '1; m_en = '0; m_edge = '0; m_pol = '1; m_both = '0;
      m_stat = '0; m_rsp_v = 0; m_rdata = '0; m_irq = 0;
      hist = {32'h0, 32'h0, 32'h0};
    end else begin
      cur = hist[1];
      prv = hist[2];
      for (int b = 0; b < N; b++) begin
        logic hit;
        if (!m_edge[b])      hit = m_pol[b] ? cur[b] : !cur[b];
        else if (m_both[b])  hit = cur[b] != prv[b];
        else if (m_pol[b])   hit = cur[b] && !prv[b];
        else                 hit = !cur[b] && prv[b];
        ev[b] = hit;
      end
      m_rsp_v = req_valid && !req_write;
      if (m_rsp_v) begin
        case (req_addr)
          6'h00: m_rdata = (m_dir & cur) | (~m_dir & m_out);
          6'h04: m_rdata = m_dir;
          6'h08: m_rdata = m_en;
          6'h0C: m_rdata = m_stat;
          6'h10: m_rdata = m_stat & m_en;
          6'h18: m_rdata = m_edge;
          6'h1C: m_rdata = m_pol;
          6'h20: m_rdata = 32'd3;
          6'h24: m_rdata = m_both;
          default: m_rdata = '0;
        endcase
      end
      clr = (req_valid && req_write && req_addr == 6'h14) ? req_wdata : '0;
      m_stat = (m_stat & ~clr) | ev;
      if (req_valid && req_write) begin
        case (req_addr)
          6'h00: m_out  = req_wdata;
          6'h04: m_dir  = req_wdata;
          6'h08: m_en   = req_wdata;
          6'h18: m_edge = req_wdata;
          6'h1C: m_pol  = req_wdata;
          6'h24: m_both = req_wdata;
          default: ;
        endcase
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
      m_irq = |(m_stat & m_en);
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      chk(irq === m_irq, "R9 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      chk(pin_oe === ~m_dir, "R2 pin_oe vs model", pin_oe, ~m_dir);
      chk(pin_out === m_out, "R3 pin_out vs model", pin_out, m_out);
      chk(rsp_valid === m_rsp_v, "R11 rsp_valid vs model", {31'b0, rsp_valid}, {31'b0, m_rsp_v});
      if (m_rsp_v) chk(rsp_rdata === m_rdata, "R1 read data vs model", rsp_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic setpin(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk(pin_oe === '0, "R12 pin_oe after reset", pin_oe, 32'h0);
    chk(irq === 1'b0, "R12 irq after reset", {31'b0, irq}, 32'h0);
    rd(6'h04, d); chk(d === 32'hFFFF_FFFF, "R12 direction reset", d, 32'hFFFF_FFFF);
    rd(6'h1C, d); chk(d === 32'hFFFF_FFFF, "R12 polarity reset", d, 32'hFFFF_FFFF);
    rd(6'h08, d); chk(d === 32'h0, "R12 enable reset", d, 32'h0);
    rd(6'h0C, d); chk(d === 32'h0, "R12 status reset", d, 32'h0);
    rd(6'h20, d); chk(d === 32'd3, "R7 version", d, 32'd3);
    rd(6'h14, d); chk(d === 32'h0, "R1 clear reads zero", d, 32'h0);
    rd(6'h3C, d); chk(d === 32'h0, "R1 unmapped reads zero", d, 32'h0);

    // R2 / R3 outputs and level readback
    wr(6'h04, 32'hFFFF_FF00);
    wr(6'h00, 32'h0000_00A5);
    chk(pin_oe === 32'h0000_00FF, "R2 low byte outputs", pin_oe, 32'h0000_00FF);
    chk(pin_out === 32'h0000_00A5, "R3 driven levels", pin_out, 32'h0000_00A5);
    setpin(32'h0000_0100);
    tick(3);
    rd(6'h00, d); chk(d === 32'h0000_01A5, "R3 mixed level read", d, 32'h0000_01A5);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h08, d); chk(d === 32'h0, "R10 write to pending leaves enable", d, 32'h0);
    setpin(32'h0);
    tick(3);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h0C, d); chk(d === 32'h0, "R8 clear all", d, 32'h0);

    // trigger configuration: 9 level-high, 10 rising, 11 falling, 12 both
    wr(6'h18, 32'h0000_1C00);
    wr(6'h1C, 32'hFFFF_F7FF);
    wr(6'h24, 32'h0000_1000);
    wr(6'h08, 32'h0000_1E00);
    chk(irq === 1'b0, "R9 quiet after config", {31'b0, irq}, 32'h0);

    // R4 latency, R5 level re-assert
    setpin(32'h0000_0200);
    tick(2); chk(irq === 1'b0, "R4 irq not before third edge", {31'b0, irq}, 32'h0);
    tick(1); chk(irq === 1'b1, "R4 irq on third edge", {31'b0, irq}, 32'h1);
    wr(6'h14, 32'h0000_0200);
    rd(6'h0C, d); chk((d & 32'h1E00) === 32'h0200, "R5 level re-asserts over clear", d & 32'h1E00, 32'h0200);
    setpin(32'h0);
    tick(3);
    wr(6'h14, 32'h0000_0200);
    rd(6'h0C, d); chk((d & 32'h1E00) === 32'h0, "R5 level gone then cleared", d & 32'h1E00, 32'h0);

    // R6 rising edge sticky
    setpin(32'h0000_0400);
    setpin(32'h0);
    tick(3); chk(irq === 1'b1, "R6 rising pulse caught", {31'b0, irq}, 32'h1);
    tick(5); chk(irq === 1'b1, "R6 sticky after pulse", {31'b0, irq}, 32'h1);
    wr(6'h14, 32'h0);
    rd(6'h0C, d); chk((d & 32'h1E00) === 32'h0400, "R8 zero write no effect", d & 32'h1E00, 32'h0400);
    wr(6'h14, 32'h0000_0400);
    chk(irq === 1'b0, "R8 one write clears", {31'b0, irq}, 32'h0);

    // R6 falling edge only
    setpin(32'h0000_0800);
    tick(4);
    rd(6'h0C, d); chk((d & 32'h1E00) === 32'h0, "R6 falling mode ignores rise", d & 32'h1E00, 32'h0);
    setpin(32'h0);
    tick(4);
    rd(6'h0C, d); chk((d & 32'h1E00) === 32'h0800, "R6 falling edge caught", d & 32'h1E00, 32'h0800);
    wr(6'h14, 32'h0000_0800);

    // R7 both edges
    setpin(32'h0000_1000);
    tick(4);
    rd(6'h0C, d); chk((d & 32'h1E00) === 32'h1000, "R7 both-edge rise", d & 32'h1E00, 32'h1000);
    wr(6'h14, 32'h0000_1000);
    setpin(32'h0);
    tick(4);
    rd(6'h0C, d); chk((d & 32'h1E00) === 32'h1000, "R7 both-edge fall", d & 32'h1E00, 32'h1000);
    wr(6'h14, 32'h0000_1000);

    // R10 simultaneous events
    setpin(32'h0000_1C00);
    tick(4);
    setpin(32'h0);
    tick(4);
    rd(6'h0C, d); chk((d & 32'h1E00) === 32'h1C00, "R10 simultaneous status", d & 32'h1E00, 32'h1C00);
    rd(6'h08, d); chk(d === 32'h0000_1E00, "R10 enable intact", d, 32'h0000_1E00);
    wr(6'h14, 32'hFFFF_FFFF);
    chk(irq === 1'b0, "R8 clear all after burst", {31'b0, irq}, 32'h0);

    // R9 masking
    wr(6'h08, 32'h0);
    setpin(32'h0000_0400);
    setpin(32'h0);
    tick(4);
    chk(irq === 1'b0, "R9 disabled pin masked", {31'b0, irq}, 32'h0);
    rd(6'h0C, d); chk((d & 32'h0400) === 32'h0400, "R9 raw status still set", d & 32'h0400, 32'h0400);
    rd(6'h10, d); chk(d === 32'h0, "R9 pending masked", d, 32'h0);
    wr(6'h08, 32'h0000_0400);
    chk(irq === 1'b1, "R9 enable exposes latch", {31'b0, irq}, 32'h1);
    wr(6'h14, 32'hFFFF_FFFF);

    // R7 polarity ignored in both-edge mode
    wr(6'h1C, 32'hFFFF_E7FF);
    wr(6'h14, 32'hFFFF_FFFF);
    setpin(32'h0000_1000);
    tick(4);
    rd(6'h0C, d); chk((d & 32'h1000) === 32'h1000, "R7 polarity ignored", d & 32'h1000, 32'h1000);

    tick(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule